// File: doc/BRIEF.md
# Transmit-Only Serial Memory Streamer

This block drives the contents of a 128-byte memory out, one bit per transmit clock, on a shared open-drain data line. It starts working as soon as reset is released. All three pins are treated as asynchronous. Each passes through a two-flop synchronizer clocked by the system clock, and edges are found by comparing each synchronized sample with the one before it.

After reset the block counts off an initialization window of nine transmit-clock rising edges and leaves the line released for the whole window. The line level seen on the first of those edges chooses the start address: high selects the top address and low selects zero. That choice is held for the rest of the window. Streaming then begins. Each word is eight data bits, most significant first, followed by one released slot. During that slot the next byte is requested from the memory through a synchronous read port. The memory has a fixed one-cycle read latency and is never stalled, so the port carries no valid/ready handshake and exerts no back-pressure.

A falling edge on the bidirectional-mode clock hands the line to the bidirectional engine for good. The mode flag rises, the line is released, and the transmit clock is ignored from then on. Only a reset brings back transmit-only mode.

Top module: `txo_streamer`

## Requirements
- R1: While reset is held and just after it, `sda_oe`, `bidir_mode` and `mem_rd_en` are all 0.
- R2: During the first nine transmit-clock rising edges after reset, `sda_oe` stays 0, so the line is never pulled low.
- R3: The synchronized data-line level on the first initialization edge sets the start address: 1 gives 0x7F and 0 gives 0x00. Levels on edges two to nine do not change the choice. The start address appears on `mem_rd_addr` after the ninth edge.
- R4: From the tenth edge on, each rising edge drives one data bit, most significant first. `sda_oe` = 1 pulls the line low for a 0 bit, and `sda_oe` = 0 releases it for a 1 bit.
- R5: On the ninth edge of every word, `sda_oe` is 0 and a one-cycle `mem_rd_en` pulse reads the next address. `mem_rd_data` is taken one clock after the pulse.
- R6: The address after 0x7F is 0x00, and streaming continues.
- R7: A falling edge on `bclk_pin` sets `bidir_mode`. It stays set through further clock activity until reset.
- R8: Once `bidir_mode` is 1, `sda_oe` stays 0 and no memory read is issued, whatever `tclk_pin` does.
- R9: `sda_oe` changes only in the cycle after a synchronized transmit-clock rise or a bidirectional-clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| tclk_pin | input | 1 | Transmit-only bit clock (asynchronous) |
| bclk_pin | input | 1 | Bidirectional-mode clock, watched for its first falling edge |
| sda_in | input | 1 | Level of the shared data line as read back |
| sda_oe | output | 1 | 1 pulls the data line low |
| bidir_mode | output | 1 | 1 once the line belongs to the bidirectional engine |
| mem_rd_en | output | 1 | One-cycle read request to the memory array |
| mem_rd_addr | output | 7 | Read address |
| mem_rd_data | input | 8 | Read data, valid one clock after `mem_rd_en` |

## Verification
A wrong bit counter shows up within one word: a data bit lands in the released slot, or the slot pulls low, and the line pattern differs from the expected byte within nine transmit clocks. A wrong start decision or a broken address increment shows on `mem_rd_addr` at the next ninth-slot fetch. The wrap is covered by a full pass over all 128 addresses and beyond. A lost or reverted mode flag is seen at once on `bidir_mode`, and later as a pulled-low line or a read pulse when transmit clocks continue after the switch.

// File: rtl/txo_pkg.sv
package txo_pkg;
  typedef enum logic [1:0] {
    PH_INIT   = 2'd0,
    PH_STREAM = 2'd1,
    PH_BIDIR  = 2'd2
  } phase_t;
endpackage

// File: rtl/txo_pin_sync.sv
module txo_pin_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl
);
  logic meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      lvl  <= RST_VAL;
    end else begin
      meta <= pin;
      lvl  <= meta;
    end
  end
endmodule

// File: rtl/txo_stream_ctrl.sv
module txo_stream_ctrl
  import txo_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tclk_rise,
  input  logic              bclk_fall,
  input  logic              sda_lvl,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              sda_oe,
  output logic              bidir_mode,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DATA_W);

  phase_t            phase;
  logic [CNT_W-1:0]  slot;
  logic              start_hi;
  logic              rd_pend;
  logic [DATA_W-1:0] shreg;

  assign bidir_mode = (phase == PH_BIDIR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_INIT;
      slot        <= '0;
      start_hi    <= 1'b0;
      rd_pend     <= 1'b0;
      shreg       <= '0;
      sda_oe      <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      rd_pend   <= mem_rd_en;
      if (rd_pend) shreg <= mem_rd_data;

      if (bclk_fall && phase != PH_BIDIR) begin
        phase  <= PH_BIDIR;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_INIT: if (tclk_rise) begin
            if (slot == '0) start_hi <= sda_lvl;
            if (slot == LAST_SLOT) begin
              phase       <= PH_STREAM;
              slot        <= '0;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= start_hi ? '1 : '0;
            end else begin
              slot <= slot + 1'b1;
            end
          end
          PH_STREAM: if (tclk_rise) begin
            if (slot == LAST_SLOT) begin
              sda_oe      <= 1'b0;
              slot        <= '0;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= mem_rd_addr + 1'b1;
            end else begin
              sda_oe <= ~shreg[DATA_W-1];
              shreg  <= shreg << 1;
              slot   <= slot + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txo_streamer.sv
module txo_streamer #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tclk_pin,
  input  logic              bclk_pin,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              bidir_mode,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data
);
  localparam int NPINS = 3;
  localparam logic [NPINS-1:0] PIN_RST = 3'b110;

  logic [NPINS-1:0] pins_raw;
  logic [NPINS-1:0] pins_lvl;
  logic             tclk_q;
  logic             bclk_q;
  logic             tclk_rise;
  logic             bclk_fall;

  assign pins_raw = {sda_in, bclk_pin, tclk_pin};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    txo_pin_sync #(.RST_VAL(PIN_RST[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins_raw[g]),
      .lvl  (pins_lvl[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tclk_q <= PIN_RST[0];
      bclk_q <= PIN_RST[1];
    end else begin
      tclk_q <= pins_lvl[0];
      bclk_q <= pins_lvl[1];
    end
  end

  assign tclk_rise = pins_lvl[0] & ~tclk_q;
  assign bclk_fall = ~pins_lvl[1] & bclk_q;

  txo_stream_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tclk_rise  (tclk_rise),
    .bclk_fall  (bclk_fall),
    .sda_lvl    (pins_lvl[2]),
    .mem_rd_data(mem_rd_data),
    .sda_oe     (sda_oe),
    .bidir_mode (bidir_mode),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr)
  );
endmodule

// File: rtl/txo_streamer_chk.sv
module txo_streamer_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic bidir_mode,
  input logic mem_rd_en,
  input logic tclk_rise,
  input logic bclk_fall
);
  logic [3:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) rise_cnt <= '0;
    else if (tclk_rise && rise_cnt != 4'hF) rise_cnt <= rise_cnt + 1'b1;
  end

  // R2
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_cnt <= 4'd9) |-> !sda_oe);

  // R7
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |=> bidir_mode);

  // R7
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |=> bidir_mode);

  // R8
  bidir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |-> (!sda_oe && !mem_rd_en));

  // R5
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R5
  fetch_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !sda_oe);

  // R9
  oe_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tclk_rise || bclk_fall) |=> $stable(sda_oe));
endmodule

bind txo_streamer txo_streamer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .bidir_mode(bidir_mode),
  .mem_rd_en (mem_rd_en),
  .tclk_rise (tclk_rise),
  .bclk_fall (bclk_fall)
);

// File: tb/txo_streamer_test.sv
module txo_streamer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tclk_pin = 1'b0;
  logic       bclk_pin = 1'b1;
  logic       host_low = 1'b0;
  logic       sda_oe;
  logic       bidir_mode;
  logic       mem_rd_en;
  logic [6:0] mem_rd_addr;
  logic [7:0] mem_rd_data;
  logic       sda_in;
  logic       rd_after_switch;
  int         checks = 0;
  int         fails = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  assign sda_in = ~(sda_oe | host_low);

  function automatic logic [7:0] mem_val(input logic [6:0] a);
    return 8'({1'b0, a} * 8'd37 + 8'd11);
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem_val(mem_rd_addr);
    if (!rst_n) rd_after_switch <= 1'b0;
    else if (mem_rd_en && bidir_mode) rd_after_switch <= 1'b1;
  end

  txo_streamer uut (
    .clk(clk), .rst_n(rst_n), .tclk_pin(tclk_pin), .bclk_pin(bclk_pin),
    .sda_in(sda_in), .sda_oe(sda_oe), .bidir_mode(bidir_mode),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // one transmit clock; oe sampled late in the high phase
  task automatic pulse(output logic oe);
    @(negedge clk) tclk_pin = 1'b1;
    repeat (4) @(negedge clk);
    oe = sda_oe;
    tclk_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tclk_pin = 1'b0; bclk_pin = 1'b1; host_low = 1'b0;
    repeat (4) @(negedge clk);
    check(sda_oe == 0 && bidir_mode == 0 && mem_rd_en == 0, "R1 reset outputs",
          {sda_oe, bidir_mode, mem_rd_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sda_oe == 0 && bidir_mode == 0, "R1 after release", {sda_oe, bidir_mode}, 0);
  endtask

  task automatic run_init(input bit first_hi, input bit later_hi);
    logic o;
    for (int i = 0; i < 9; i++) begin
      host_low = (i == 0) ? !first_hi : (i < 8 ? !later_hi : 1'b0);
      pulse(o);
      check(o == 1'b0, "R2 init line released", o, 0);
    end
    host_low = 1'b0;
    check(mem_rd_addr == (first_hi ? 7'h7F : 7'h00), "R3 start address",
          mem_rd_addr, first_hi ? 127 : 0);
  endtask

  task automatic run_word(input logic [6:0] a);
    logic o;
    logic [7:0] d;
    d = mem_val(a);
    for (int b = 7; b >= 0; b--) begin
      pulse(o);
      check(o == !d[b], "R4 data bit", o, !d[b]);
    end
    pulse(o);
    check(o == 1'b0, "R5 ninth slot released", o, 0);
    if (a == 7'h7F)
      check(mem_rd_addr == 7'h00, "R6 wrap", mem_rd_addr, 0);
    else
      check(mem_rd_addr == a + 7'd1, "R5 next fetch address", mem_rd_addr, a + 1);
  endtask

  initial begin
    logic o;
    do_reset();
    run_init(1'b0, 1'b0);
    for (int w = 0; w < 131; w++) run_word(7'(w));

    do_reset();
    run_init(1'b1, 1'b0);           // R3 later low levels ignored
    run_word(7'h7F);
    run_word(7'h00);
    run_word(7'h01);

    do_reset();
    run_init(1'b0, 1'b1);           // R3 later high levels ignored
    run_word(7'h00);
    run_word(7'h01);

    do_reset();
    run_init(1'b1, 1'b1);
    run_word(7'h7F);
    for (int b = 0; b < 3; b++) pulse(o);
    @(negedge clk) bclk_pin = 1'b0;
    repeat (6) @(negedge clk);
    check(bidir_mode == 1'b1, "R7 switch on falling edge", bidir_mode, 1);
    check(sda_oe == 1'b0, "R8 line released on switch", sda_oe, 0);
    for (int i = 0; i < 20; i++) begin
      pulse(o);
      check(o == 1'b0, "R8 transmit clock ignored", o, 0);
    end
    check(rd_after_switch == 1'b0, "R8 no fetch after switch", rd_after_switch, 0);
    bclk_pin = 1'b1;
    repeat (6) @(negedge clk);
    bclk_pin = 1'b0;
    repeat (6) @(negedge clk);
    check(bidir_mode == 1'b1, "R7 mode stays set", bidir_mode, 1);

    do_reset();
    check(bidir_mode == 1'b0, "R7 reset returns to transmit-only", bidir_mode, 0);
    for (int i = 0; i < 4; i++) pulse(o);
    @(negedge clk) bclk_pin = 1'b0;   // switch in the middle of initialization
    repeat (6) @(negedge clk);
    check(bidir_mode == 1'b1, "R7 switch during init", bidir_mode, 1);
    for (int i = 0; i < 12; i++) begin
      pulse(o);
      check(o == 1'b0, "R8 quiet after init switch", o, 0);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule